// File: doc/BRIEF.md
# Atomic read-modify-write execution unit

This block carries out one atomic memory operation for a 64-bit style integer core. A single request supplies an operation code, an access size, two ordering flags (acquire and release), the effective address and the register operand. The unit checks the request, reads the memory location, combines the loaded value with the operand, and writes the combined value back. The loaded value is handed to the destination register only once the write has been acknowledged without error.

Any phase can abort. The possible causes are an illegal operation or size, a misaligned address, a read that returns an error, or a write that returns an error. On an abort the unit raises a trap pulse that carries a cause code and the effective address, and the destination register is not written. The caller redirects the next PC to its trap handler when it sees that pulse.

The request port and the memory request port are valid/ready. A request is taken on a cycle where valid and ready are both high. While ready is low, the source must hold valid and every field steady. The memory response port is valid/ready as well. The unit raises response-ready only after its request has been accepted, and never before the cycle that follows that acceptance. The result and trap outputs are plain one-cycle pulses with no back-pressure.

Top module: `amo_unit`

## Requirements
- R1: After reset the unit is idle: `busy` is low and `req_ready` is high. A request is accepted only while idle. `busy` is high from the cycle after acceptance through the cycle that pulses `rd_we` or `trap_valid`, and is low again the cycle after that.
- R2: An operation code above 8, or a size code other than 2 (word) or 3 (doubleword), produces a trap with cause 2 and no memory request.
- R3: A legal request whose address is not a multiple of its access size (4 bytes for size 2, 8 bytes for size 3) produces a trap with cause 6 and no memory request.
- R4: The read is a memory request with `mem_req_write` low, the request address and size, acquire equal to the request's aq flag, and release equal to aq AND rl. While `mem_req_ready` is low, the request and its fields are held steady.
- R5: A read response with the error flag set produces a trap with cause 5 and issues no write.
- R6: The write data is the combination of the register operand A and the loaded value M. The operation codes are: 0 swap (A), 1 add (A+M), 2 xor, 3 and, 4 or, 5 signed minimum, 6 signed maximum, 7 unsigned minimum, 8 unsigned maximum.
- R7: For a word operation, only bits 31:0 of the read data are used. The loaded value is sign-extended from bit 31. Comparisons and arithmetic use 32-bit values with bit 31 as the sign. Write data bits 63:32 are zero.
- R8: The write request has `mem_req_write` high, acquire equal to aq AND rl, and release equal to rl.
- R9: A write response with the error flag set produces a trap with cause 7, and `rd_we` is not pulsed.
- R10: `rd_we` pulses for one cycle only in the cycle after an error-free write response. At that pulse `rd_data` holds the loaded value, sign-extended for word operations.
- R11: `rd_we` and `trap_valid` are never high together. At a trap, `trap_addr` equals the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request (idle) |
| req_op | input | 4 | Operation code (0..8 legal) |
| req_size | input | 2 | Access size code, 2 word, 3 doubleword |
| req_aq | input | 1 | Acquire ordering flag |
| req_rl | input | 1 | Release ordering flag |
| req_addr | input | XLEN | Effective address |
| req_rs2 | input | XLEN | Register operand |
| busy | output | 1 | Operation in flight |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_size | output | 2 | Access size code |
| mem_req_acq | output | 1 | Acquire ordering for this access |
| mem_req_rel | output | 1 | Release ordering for this access |
| mem_req_addr | output | XLEN | Access address |
| mem_req_wdata | output | XLEN | Write data |
| mem_rsp_valid | input | 1 | Memory response offered |
| mem_rsp_ready | output | 1 | Unit waits for a response |
| mem_rsp_err | input | 1 | Response reports a failed access |
| mem_rsp_rdata | input | XLEN | Read data |
| rd_we | output | 1 | Destination write pulse |
| rd_data | output | XLEN | Value for the destination register |
| trap_valid | output | 1 | Trap pulse |
| trap_cause | output | 5 | Trap cause code |
| trap_addr | output | XLEN | Faulting effective address |

## Verification
The bench builds the unit with its default 64-bit register width, so both legal sizes are reachable. It sweeps all nine operations at both sizes with operand pairs placed on the signed and unsigned boundaries, and junk in the upper read bits for word cases. Across that sweep it cycles through all four aq/rl combinations and memory stalls of zero to two cycles. Separate sweeps cover every low address offset at both sizes, every illegal size and operation code, and error responses in the read phase and in the write phase, so each trap cause and the held-off register write can be observed.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_XOR  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8
  } amo_op_e;

  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_DBL  = 2'd3;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL     = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT    = 5'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_MISALIGN = 5'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT    = 5'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_COMPUTE,
    ST_WRITE,
    ST_COMMIT,
    ST_TRAP
  } amo_state_e;

endpackage

// File: rtl/amo_check.sv
module amo_check
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op,
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] addr,
  output logic            legal,
  output logic            misaligned
);
  localparam bit DBL_OK = (XLEN >= 64);

  logic size_ok;
  logic op_ok;

  always_comb begin
    size_ok    = (size == SZ_WORD) || (DBL_OK && (size == SZ_DBL));
    op_ok      = (op <= 4'(OP_MAXU));
    legal      = size_ok && op_ok;
    misaligned = (size == SZ_DBL) ? (addr[2:0] != 3'd0) : (addr[1:0] != 2'd0);
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op,
  input  logic            is_word,
  input  logic [XLEN-1:0] src_reg,
  input  logic [XLEN-1:0] src_mem,
  output logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] a;
  logic [XLEN-1:0] b;
  logic [XLEN-1:0] r;
  logic            lt_s;
  logic            lt_u;

  // Word operands are sign-extended so that full-width compares give the
  // 32-bit signed and unsigned orderings; the write keeps only 32 bits.
  generate
    if (XLEN > 32) begin : g_wide
      always_comb begin
        a = is_word ? {{(XLEN-32){src_reg[31]}}, src_reg[31:0]} : src_reg;
        b = is_word ? {{(XLEN-32){src_mem[31]}}, src_mem[31:0]} : src_mem;
      end
      assign wdata = is_word ? {{(XLEN-32){1'b0}}, r[31:0]} : r;
    end else begin : g_narrow
      logic unused_size;
      assign unused_size = is_word;
      assign a     = src_reg;
      assign b     = src_mem;
      assign wdata = r;
    end
  endgenerate

  always_comb begin
    lt_s = $signed(a) < $signed(b);
    lt_u = a < b;
    case (op)
      OP_SWAP: r = a;
      OP_ADD:  r = a + b;
      OP_XOR:  r = a ^ b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_MIN:  r = lt_s ? a : b;
      OP_MAX:  r = lt_s ? b : a;
      OP_MINU: r = lt_u ? a : b;
      OP_MAXU: r = lt_u ? b : a;
      default: r = a;
    endcase
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_fire,
  input  logic               legal,
  input  logic               misaligned,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_err,
  output amo_state_e         state,
  output logic               issued,
  output logic [CAUSE_W-1:0] cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
      cause  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_fire) state <= ST_CHECK;
        end
        ST_CHECK: begin
          issued <= 1'b0;
          if (!legal) begin
            cause <= CAUSE_ILLEGAL;
            state <= ST_TRAP;
          end else if (misaligned) begin
            cause <= CAUSE_ST_MISALIGN;
            state <= ST_TRAP;
          end else begin
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (!issued) begin
            if (mem_req_ready) issued <= 1'b1;
          end else if (mem_rsp_valid) begin
            issued <= 1'b0;
            if (mem_rsp_err) begin
              cause <= CAUSE_LD_FAULT;
              state <= ST_TRAP;
            end else begin
              state <= ST_COMPUTE;
            end
          end
        end
        ST_COMPUTE: state <= ST_WRITE;
        ST_WRITE: begin
          if (!issued) begin
            if (mem_req_ready) issued <= 1'b1;
          end else if (mem_rsp_valid) begin
            issued <= 1'b0;
            if (mem_rsp_err) begin
              cause <= CAUSE_ST_FAULT;
              state <= ST_TRAP;
            end else begin
              state <= ST_COMMIT;
            end
          end
        end
        ST_COMMIT: state <= ST_IDLE;
        ST_TRAP:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [3:0]         req_op,
  input  logic [1:0]         req_size,
  input  logic               req_aq,
  input  logic               req_rl,
  input  logic [XLEN-1:0]    req_addr,
  input  logic [XLEN-1:0]    req_rs2,
  output logic               busy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [1:0]         mem_req_size,
  output logic               mem_req_acq,
  output logic               mem_req_rel,
  output logic [XLEN-1:0]    mem_req_addr,
  output logic [XLEN-1:0]    mem_req_wdata,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic               mem_rsp_err,
  input  logic [XLEN-1:0]    mem_rsp_rdata,
  output logic               rd_we,
  output logic [XLEN-1:0]    rd_data,
  output logic               trap_valid,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_addr
);
  amo_state_e         state;
  logic               issued;
  logic [CAUSE_W-1:0] cause;
  logic               req_fire;
  logic               legal;
  logic               misaligned;
  logic               in_mem;
  logic               load_en;

  logic [3:0]         op_q;
  logic [1:0]         size_q;
  logic               aq_q;
  logic               rl_q;
  logic [XLEN-1:0]    addr_q;
  logic [XLEN-1:0]    rs2_q;
  logic [XLEN-1:0]    loaded_q;
  logic [XLEN-1:0]    wdata_q;
  logic [XLEN-1:0]    rdata_ext;
  logic [XLEN-1:0]    alu_out;
  logic               is_word;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign busy      = (state != ST_IDLE);
  assign is_word   = (size_q == SZ_WORD);
  assign in_mem    = (state == ST_READ) || (state == ST_WRITE);
  assign load_en   = (state == ST_READ) && issued && mem_rsp_valid && !mem_rsp_err;

  generate
    if (XLEN > 32) begin : g_ext
      assign rdata_ext = is_word ? {{(XLEN-32){mem_rsp_rdata[31]}}, mem_rsp_rdata[31:0]}
                                 : mem_rsp_rdata;
    end else begin : g_noext
      assign rdata_ext = mem_rsp_rdata;
    end
  endgenerate

  amo_check #(.XLEN(XLEN)) u_check (
    .op        (op_q),
    .size      (size_q),
    .addr      (addr_q),
    .legal     (legal),
    .misaligned(misaligned)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op     (op_q),
    .is_word(is_word),
    .src_reg(rs2_q),
    .src_mem(loaded_q),
    .wdata  (alu_out)
  );

  amo_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_fire     (req_fire),
    .legal        (legal),
    .misaligned   (misaligned),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err  (mem_rsp_err),
    .state        (state),
    .issued       (issued),
    .cause        (cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= '0;
      size_q   <= '0;
      aq_q     <= 1'b0;
      rl_q     <= 1'b0;
      addr_q   <= '0;
      rs2_q    <= '0;
      loaded_q <= '0;
      wdata_q  <= '0;
    end else begin
      if (req_fire) begin
        op_q   <= req_op;
        size_q <= req_size;
        aq_q   <= req_aq;
        rl_q   <= req_rl;
        addr_q <= req_addr;
        rs2_q  <= req_rs2;
      end
      if (load_en) loaded_q <= rdata_ext;
      if (state == ST_COMPUTE) wdata_q <= alu_out;
    end
  end

  // Read: acquire = aq, release = aq & rl. Write: acquire = aq & rl, release = rl.
  assign mem_req_valid = in_mem && !issued;
  assign mem_rsp_ready = in_mem && issued;
  assign mem_req_write = (state == ST_WRITE);
  assign mem_req_acq   = mem_req_write ? (aq_q && rl_q) : aq_q;
  assign mem_req_rel   = mem_req_write ? rl_q : (aq_q && rl_q);
  assign mem_req_size  = size_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  assign rd_we      = (state == ST_COMMIT);
  assign rd_data    = loaded_q;
  assign trap_valid = (state == ST_TRAP);
  assign trap_cause = cause;
  assign trap_addr  = addr_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_aq,
  input logic               req_rl,
  input logic               busy,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_write,
  input logic [1:0]         mem_req_size,
  input logic               mem_req_acq,
  input logic               mem_req_rel,
  input logic [XLEN-1:0]    mem_req_addr,
  input logic [XLEN-1:0]    mem_req_wdata,
  input logic               mem_rsp_valid,
  input logic               mem_rsp_ready,
  input logic               mem_rsp_err,
  input logic               rd_we,
  input logic               trap_valid,
  input logic [CAUSE_W-1:0] trap_cause
);
  logic cap_aq;
  logic cap_rl;
  logic seen_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_aq   <= 1'b0;
      cap_rl   <= 1'b0;
      seen_req <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_aq   <= req_aq;
      cap_rl   <= req_rl;
      seen_req <= 1'b0;
    end else if (mem_req_valid) begin
      seen_req <= 1'b1;
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);

  assert_hold_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rd_we && !trap_valid |=> busy);

  // R2 rejects take the same no-access path
  assert_no_mem_on_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && (trap_cause == CAUSE_ST_MISALIGN || trap_cause == CAUSE_ILLEGAL) |-> !seen_req);

  assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && $stable(mem_req_wdata) && $stable(mem_req_size));

  assert_read_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> mem_req_acq == cap_aq && mem_req_rel == (cap_aq && cap_rl));

  assert_write_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_acq == (cap_aq && cap_rl) && mem_req_rel == cap_rl);

  generate
    if (XLEN > 32) begin : g_upper
      assert_word_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write && mem_req_size == SZ_WORD |-> mem_req_wdata[XLEN-1:32] == '0);
    end
  endgenerate

  assert_commit_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> $past(mem_rsp_valid && mem_rsp_ready && !mem_rsp_err && mem_req_write));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_we && trap_valid));
endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_aq       (req_aq),
  .req_rl       (req_rl),
  .busy         (busy),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_size (mem_req_size),
  .mem_req_acq  (mem_req_acq),
  .mem_req_rel  (mem_req_rel),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready),
  .mem_rsp_err  (mem_rsp_err),
  .rd_we        (rd_we),
  .trap_valid   (trap_valid),
  .trap_cause   (trap_cause)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [3:0]      req_op = '0;
  logic [1:0]      req_size = '0;
  logic            req_aq = 1'b0;
  logic            req_rl = 1'b0;
  logic [XLEN-1:0] req_addr = '0;
  logic [XLEN-1:0] req_rs2 = '0;
  logic            busy;
  logic            mem_req_valid;
  logic            mem_req_ready = 1'b0;
  logic            mem_req_write;
  logic [1:0]      mem_req_size;
  logic            mem_req_acq;
  logic            mem_req_rel;
  logic [XLEN-1:0] mem_req_addr;
  logic [XLEN-1:0] mem_req_wdata;
  logic            mem_rsp_valid = 1'b0;
  logic            mem_rsp_ready;
  logic            mem_rsp_err = 1'b0;
  logic [XLEN-1:0] mem_rsp_rdata = '0;
  logic            rd_we;
  logic [XLEN-1:0] rd_data;
  logic            trap_valid;
  logic [4:0]      trap_cause;
  logic [XLEN-1:0] trap_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  amo_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_size(req_size),
    .req_aq(req_aq), .req_rl(req_rl), .req_addr(req_addr), .req_rs2(req_rs2),
    .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_size(mem_req_size), .mem_req_acq(mem_req_acq), .mem_req_rel(mem_req_rel),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_rdata(mem_rsp_rdata),
    .rd_we(rd_we), .rd_data(rd_data),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_addr(trap_addr)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_combine(input logic [3:0] op, input logic w,
                                              input logic [63:0] a, input logic [63:0] m);
    logic [31:0] x, y, r32;
    logic [63:0] r64;
    x = a[31:0];
    y = m[31:0];
    r32 = '0;
    r64 = '0;
    if (w) begin
      case (op)
        4'd0: r32 = x;
        4'd1: r32 = x + y;
        4'd2: r32 = x ^ y;
        4'd3: r32 = x & y;
        4'd4: r32 = x | y;
        4'd5: r32 = ($signed(x) < $signed(y)) ? x : y;
        4'd6: r32 = ($signed(x) > $signed(y)) ? x : y;
        4'd7: r32 = (x < y) ? x : y;
        default: r32 = (x > y) ? x : y;
      endcase
      return {32'h0, r32};
    end
    case (op)
      4'd0: r64 = a;
      4'd1: r64 = a + m;
      4'd2: r64 = a ^ m;
      4'd3: r64 = a & m;
      4'd4: r64 = a | m;
      4'd5: r64 = ($signed(a) < $signed(m)) ? a : m;
      4'd6: r64 = ($signed(a) > $signed(m)) ? a : m;
      4'd7: r64 = (a < m) ? a : m;
      default: r64 = (a > m) ? a : m;
    endcase
    return r64;
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [1:0] sz, input logic aq, input logic rl,
                        input logic [63:0] addr, input logic [63:0] rs2, input logic [63:0] mval,
                        input logic rerr, input logic werr, input int stall);
    logic legal, mis, exp_trap, is_w;
    logic [4:0] exp_cause;
    logic [63:0] loaded, exp_w;
    string ttag, dtag;
    int nr, nw, stall_left;
    logic rsp_pend, pend_err, got_done, got_trap;
    logic [63:0] o_rd, o_taddr, r_addr, w_addr, w_data;
    logic [4:0] o_cause;
    logic r_acq, r_rel, w_acq, w_rel;
    logic [1:0] r_size;

    legal = ((sz == 2'd2) || (sz == 2'd3)) && (op <= 4'd8);
    mis   = (sz == 2'd3) ? (addr[2:0] != 3'd0) : (addr[1:0] != 2'd0);
    is_w  = (sz == 2'd2);
    loaded = is_w ? {{32{mval[31]}}, mval[31:0]} : mval;
    exp_w  = exp_combine(op, is_w, rs2, mval);
    exp_trap = 1'b1;
    exp_cause = 5'd0;
    ttag = "R11";
    if (!legal) begin exp_cause = 5'd2; ttag = "R2"; end
    else if (mis) begin exp_cause = 5'd6; ttag = "R3"; end
    else if (rerr) begin exp_cause = 5'd5; ttag = "R5"; end
    else if (werr) begin exp_cause = 5'd7; ttag = "R9"; end
    else exp_trap = 1'b0;
    dtag = is_w ? "R7" : "R10";

    req_op = op; req_size = sz; req_aq = aq; req_rl = rl; req_addr = addr; req_rs2 = rs2;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "busy after accept", 64'(busy), 64'd1);

    nr = 0; nw = 0; stall_left = stall; rsp_pend = 1'b0; pend_err = 1'b0;
    got_done = 1'b0; got_trap = 1'b0; o_rd = '0; o_taddr = '0; o_cause = '0;
    r_addr = '0; w_addr = '0; w_data = '0; r_acq = 0; r_rel = 0; w_acq = 0; w_rel = 0; r_size = '0;
    for (int cyc = 0; cyc < 64; cyc++) begin
      if (rd_we || trap_valid) begin
        got_done = rd_we; got_trap = trap_valid;
        o_rd = rd_data; o_cause = trap_cause; o_taddr = trap_addr;
        break;
      end
      mem_rsp_valid = 1'b0;
      if (rsp_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = pend_err;
        mem_rsp_rdata = mval;
        rsp_pend = 1'b0;
      end
      mem_req_ready = 1'b0;
      if (mem_req_valid) begin
        if (stall_left > 0) stall_left--;
        else begin
          mem_req_ready = 1'b1;
          stall_left = stall;
          rsp_pend = 1'b1;
          if (mem_req_write) begin
            nw++; w_addr = mem_req_addr; w_data = mem_req_wdata;
            w_acq = mem_req_acq; w_rel = mem_req_rel; pend_err = werr;
          end else begin
            nr++; r_addr = mem_req_addr; r_size = mem_req_size;
            r_acq = mem_req_acq; r_rel = mem_req_rel; pend_err = rerr;
          end
        end
      end
      @(negedge clk);
    end
    mem_rsp_valid = 1'b0;
    mem_req_ready = 1'b0;

    if (exp_trap) begin
      chk(ttag, "trap pulse", 64'(got_trap), 64'd1);
      chk(ttag, "no register write on trap", 64'(got_done), 64'd0);
      chk(ttag, "trap cause", 64'(o_cause), 64'(exp_cause));
      chk("R11", "trap address", o_taddr, addr);
    end else begin
      chk("R10", "commit pulse", 64'(got_done), 64'd1);
      chk("R11", "no trap on success", 64'(got_trap), 64'd0);
      chk(dtag, "rd value", o_rd, loaded);
    end
    chk(legal && !mis ? "R4" : ttag, "read count", 64'(nr), (legal && !mis) ? 64'd1 : 64'd0);
    chk(rerr ? "R5" : "R8", "write count", 64'(nw), (legal && !mis && !rerr) ? 64'd1 : 64'd0);
    if (nr > 0) begin
      chk("R4", "read addr", r_addr, addr);
      chk("R4", "read size", 64'(r_size), 64'(sz));
      chk("R4", "read acquire", 64'(r_acq), 64'(aq));
      chk("R4", "read release", 64'(r_rel), 64'(aq & rl));
    end
    if (nw > 0) begin
      chk(is_w ? "R7" : "R6", "write data", w_data, exp_w);
      chk("R8", "write addr", w_addr, addr);
      chk("R8", "write acquire", 64'(w_acq), 64'(aq & rl));
      chk("R8", "write release", 64'(w_rel), 64'(rl));
    end
    @(negedge clk);
    chk("R1", "idle after finish", 64'(busy), 64'd0);
    chk("R1", "ready after finish", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa [4];
    logic [63:0] pm [4];
    pa[0] = 64'h0000_0000_7FFF_FFFF; pm[0] = 64'hFFFF_FFFF_8000_0000;
    pa[1] = 64'h8000_0000_0000_0001; pm[1] = 64'h7FFF_FFFF_FFFF_FFFF;
    pa[2] = 64'h1234_5678_9ABC_DEF0; pm[2] = 64'h0FED_CBA9_8765_4321;
    pa[3] = 64'hFFFF_FFFF_FFFF_FFFF; pm[3] = 64'hA5A5_A5A5_0000_0001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset busy", 64'(busy), 64'd0);
    chk("R1", "reset ready", 64'(req_ready), 64'd1);
    chk("R4", "reset mem request", 64'(mem_req_valid), 64'd0);
    chk("R10", "reset rd_we", 64'(rd_we), 64'd0);
    chk("R11", "reset trap", 64'(trap_valid), 64'd0);

    // R6 / R7 / R8: every operation, both sizes, boundary operand pairs
    for (int op = 0; op < 9; op++)
      for (int s = 2; s < 4; s++)
        for (int p = 0; p < 4; p++)
          run_op(4'(op), 2'(s), p[0], p[1] ^ op[0],
                 (s == 2) ? 64'h1000 + 64'(4 * p) : 64'h2000 + 64'(8 * p),
                 pa[p], pm[p], 1'b0, 1'b0, (op + p) % 3);

    // R3: every low address offset at both sizes
    for (int s = 2; s < 4; s++)
      for (int lo = 1; lo < 8; lo++)
        run_op(4'd1, 2'(s), 1'b1, 1'b1, 64'h3000 + 64'(lo), pa[2], pm[2], 1'b0, 1'b0, 0);

    // R2: illegal sizes and operation codes
    for (int s = 0; s < 2; s++)
      run_op(4'd0, 2'(s), 1'b0, 1'b0, 64'h4000, pa[0], pm[0], 1'b0, 1'b0, 0);
    for (int op = 9; op < 16; op++)
      run_op(4'(op), 2'd3, 1'b0, 1'b1, 64'h4008, pa[1], pm[1], 1'b0, 1'b0, 0);

    // R5 and R9: error responses in each phase
    for (int s = 2; s < 4; s++) begin
      run_op(4'd1, 2'(s), 1'b1, 1'b0, 64'h5000, pa[2], pm[2], 1'b1, 1'b0, 1);
      run_op(4'd6, 2'(s), 1'b0, 1'b1, 64'h5010, pa[1], pm[1], 1'b0, 1'b1, 2);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule